// File: doc/BRIEF.md
# Configurable Logic Cluster

This block is a soft model of one programmable logic tile. Ten data inputs feed a pool shared by four logic elements. Each element has a 4-input lookup table, a D flip-flop and a 2:1 output select. A full local crossbar lets every element input pick any data input, the registered value of any element, or a constant zero. Which data input lands on which element pin is decided by configuration alone, so the tile's inputs are interchangeable.

All configuration (truth tables, crossbar selects and output selects) is held in a 132-bit serial chain. The chain is loaded on its own clock while a load-enable pin is high, and the data outputs are held low during loading. After loading, the tile computes on the user clock. A synchronous reset on that clock clears the four flip-flops and leaves the configuration untouched.

The tile has no streaming data path: data inputs are sampled every cycle and outputs are plain levels. For that reason it has no valid/ready handshake, and back-pressure does not apply.

Top module: `lut_cluster`

## Requirements
- R1: On each rising `cfg_clk` with `cfg_en` high, the chain shifts left by one and takes `cfg_din` into bit 0. A 132-bit image is therefore sent most significant bit first. Element e owns chain bits [33e+32 : 33e]. Within that slice, bits [15:0] are the truth table, bits [16+4k+3 : 16+4k] are the source select of element input k (k = 0..3), and bit 32 is the output select.
- R2: Rising `cfg_clk` edges while `cfg_en` is low leave the configuration unchanged, whatever `cfg_din` carries.
- R3: Source select codes 0 to 9 pick `din[code]`. Codes 10 to 13 pick the flip-flop value of element code-10. Codes 14 and 15 give constant 0.
- R4: The table output of an element is the truth-table bit at index {in3,in2,in1,in0}, with input 0 as the least significant index bit.
- R5: On every rising `clk` with `rst` low, each element flip-flop takes that element's current table output.
- R6: On a rising `clk` with `rst` high, all four flip-flops become 0. Configuration is not affected.
- R7: With output select 0, `dout[e]` is the table output of element e (combinational). With output select 1, `dout[e]` is the flip-flop of element e.
- R8: While `cfg_en` is high, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock for the element flip-flops |
| rst | input | 1 | Synchronous active-high flip-flop clear |
| cfg_clk | input | 1 | Configuration chain clock |
| cfg_en | input | 1 | Configuration shift enable; forces outputs low |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| din | input | 10 | Tile data inputs |
| dout | output | 4 | Tile data outputs, one per element |

## Verification
The bench loads several configurations that expose the corner cases.

- One LUT tests the index order: it is true only at index 1. A design that reversed the order of the index bits would fire on the wrong input.
- Several element pins are tied to the same data input, to constant-zero codes and to feedback codes. A crossbar that decoded codes 10 to 15 wrongly would show this at once.
- A registered element inverts its own value and so toggles every cycle. A flip-flop that captured the wrong cycle, or that ignored reset, would break this pattern.
- Clock pulses are sent on the configuration clock with the enable low and random data on `cfg_din`. A chain that shifted anyway would corrupt every later output.
- The outputs are sampled in the middle of a load. A design that did not force them low there would show a nonzero value.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;
  localparam int unsigned DEF_NUM_IN   = 10;
  localparam int unsigned DEF_NUM_ELEM = 4;
  localparam int unsigned DEF_LUT_K    = 4;

  function automatic int unsigned sel_width(input int unsigned n_src);
    return (n_src <= 2) ? 1 : $clog2(n_src);
  endfunction

  function automatic int unsigned elem_cfg_width(input int unsigned k, input int unsigned sw);
    return (1 << k) + k * sw + 1;
  endfunction

  localparam int unsigned DEF_SEL_W = sel_width(DEF_NUM_IN + DEF_NUM_ELEM);
  localparam int unsigned DEF_CFG_W = DEF_NUM_ELEM * elem_cfg_width(DEF_LUT_K, DEF_SEL_W);
endpackage

// File: rtl/lut_cluster_cfg_chain.sv
module lut_cluster_cfg_chain #(
  parameter int unsigned WIDTH = 132
) (
  input  logic             cfg_clk,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic [WIDTH-1:0] cfg_q
);
  always_ff @(posedge cfg_clk) begin
    if (cfg_en) cfg_q <= {cfg_q[WIDTH-2:0], cfg_din};
  end
endmodule

// File: rtl/lut_cluster_src_mux.sv
module lut_cluster_src_mux #(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] src,
  input  logic [SEL_W-1:0]   sel,
  output logic               y
);
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == i[SEL_W-1:0]) y = src[i];
    end
  end
endmodule

// File: rtl/lut_cluster_elem.sv
module lut_cluster_elem #(
  parameter int unsigned LUT_K   = 4,
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned SEL_W   = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_SRC-1:0]                  src,
  input  logic [(1<<LUT_K)+LUT_K*SEL_W:0]     cfg,
  output logic                                lut_o,
  output logic                                ff_q,
  output logic                                out
);
  localparam int unsigned TT_W   = 1 << LUT_K;
  localparam int unsigned ECFG_W = TT_W + LUT_K * SEL_W + 1;

  logic [TT_W-1:0]  truth;
  logic [LUT_K-1:0] pin;
  logic             use_reg;

  assign truth   = cfg[TT_W-1:0];
  assign use_reg = cfg[ECFG_W-1];

  for (genvar k = 0; k < LUT_K; k++) begin : g_pin
    lut_cluster_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .src (src),
      .sel (cfg[TT_W + k*SEL_W +: SEL_W]),
      .y   (pin[k])
    );
  end

  assign lut_o = truth[pin];

  always_ff @(posedge clk) begin
    if (rst) ff_q <= 1'b0;
    else     ff_q <= lut_o;
  end

  assign out = use_reg ? ff_q : lut_o;
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster #(
  parameter int unsigned NUM_IN   = lut_cluster_pkg::DEF_NUM_IN,
  parameter int unsigned NUM_ELEM = lut_cluster_pkg::DEF_NUM_ELEM,
  parameter int unsigned LUT_K    = lut_cluster_pkg::DEF_LUT_K
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_clk,
  input  logic                cfg_en,
  input  logic                cfg_din,
  input  logic [NUM_IN-1:0]   din,
  output logic [NUM_ELEM-1:0] dout
);
  localparam int unsigned NUM_SRC = NUM_IN + NUM_ELEM;
  localparam int unsigned SEL_W   = lut_cluster_pkg::sel_width(NUM_SRC);
  localparam int unsigned ECFG_W  = lut_cluster_pkg::elem_cfg_width(LUT_K, SEL_W);
  localparam int unsigned CFG_W   = NUM_ELEM * ECFG_W;

  logic [CFG_W-1:0]    cfg_q;
  logic [NUM_SRC-1:0]  src_bus;
  logic [NUM_ELEM-1:0] lut_out;
  logic [NUM_ELEM-1:0] ff_q;
  logic [NUM_ELEM-1:0] elem_out;
  logic [NUM_ELEM-1:0] reg_sel;

  lut_cluster_cfg_chain #(.WIDTH(CFG_W)) u_chain (
    .cfg_clk (cfg_clk),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .cfg_q   (cfg_q)
  );

  assign src_bus = {ff_q, din};

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    assign reg_sel[e] = cfg_q[e*ECFG_W + ECFG_W - 1];
    lut_cluster_elem #(.LUT_K(LUT_K), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_elem (
      .clk   (clk),
      .rst   (rst),
      .src   (src_bus),
      .cfg   (cfg_q[e*ECFG_W +: ECFG_W]),
      .lut_o (lut_out[e]),
      .ff_q  (ff_q[e]),
      .out   (elem_out[e])
    );
  end

  assign dout = cfg_en ? '0 : elem_out;
endmodule

// File: rtl/lut_cluster_chk.sv
module lut_cluster_chk #(
  parameter int unsigned NE    = lut_cluster_pkg::DEF_NUM_ELEM,
  parameter int unsigned CFG_W = lut_cluster_pkg::DEF_CFG_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_clk,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic [CFG_W-1:0] cfg_q,
  input logic [NE-1:0]    lut_out,
  input logic [NE-1:0]    ff_q,
  input logic [NE-1:0]    reg_sel,
  input logic [NE-1:0]    dout
);
  AST_SHIFT_IN: assert property (@(posedge cfg_clk) disable iff (rst)
    cfg_en |=> cfg_q[0] == $past(cfg_din)); // R1
  AST_CFG_HOLD: assert property (@(posedge cfg_clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q)); // R2
  AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ff_q == $past(lut_out)); // R5
  AST_FF_CLEAR: assert property (@(posedge clk)
    rst |=> ff_q == '0); // R6
  AST_OUT_REG: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> (dout & reg_sel) == (ff_q & reg_sel)); // R7
  AST_OUT_COMB: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> (dout & ~reg_sel) == (lut_out & ~reg_sel)); // R7
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> dout == '0); // R8
endmodule

bind lut_cluster lut_cluster_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_clk (cfg_clk),
  .cfg_en  (cfg_en),
  .cfg_din (cfg_din),
  .cfg_q   (cfg_q),
  .lut_out (lut_out),
  .ff_q    (ff_q),
  .reg_sel (reg_sel),
  .dout    (dout)
);

// File: tb/lut_cluster_bench.sv
module lut_cluster_bench;
  logic       clk = 0, rst = 1, cfg_clk = 0, cfg_en = 1, cfg_din = 0;
  logic [9:0] din = '0;
  logic [3:0] dout;

  always #10 clk = ~clk;

  lut_cluster u_lut_cluster (
    .clk(clk), .rst(rst), .cfg_clk(cfg_clk), .cfg_en(cfg_en),
    .cfg_din(cfg_din), .din(din), .dout(dout)
  );

  int checks = 0, errors = 0;
  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t sb[$];

  logic [15:0] m_tt [4];
  logic [3:0]  m_sel [4][4];
  logic        m_reg [4];
  logic [3:0]  m_ff;

  function automatic logic src_val(input logic [3:0] c, input logic [9:0] d, input logic [3:0] f);
    if (c < 10) return d[c];
    if (c < 14) return f[c - 10];
    return 1'b0;
  endfunction

  function automatic logic [3:0] lut_vals(input logic [9:0] d, input logic [3:0] f);
    logic [3:0] v;
    for (int e = 0; e < 4; e++) begin
      logic [3:0] idx;
      for (int k = 0; k < 4; k++) idx[k] = src_val(m_sel[e][k], d, f);
      v[e] = m_tt[e][idx];
    end
    return v;
  endfunction

  function automatic logic [3:0] out_vals(input logic [9:0] d, input logic [3:0] f);
    logic [3:0] lv, o;
    lv = lut_vals(d, f);
    for (int e = 0; e < 4; e++) o[e] = m_reg[e] ? f[e] : lv[e];
    return o;
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(dout, it.exp, it.tag);
    end
  end

  task automatic step(input logic [9:0] nd, input logic nrst, input string tag);
    @(posedge clk);
    m_ff = rst ? 4'b0 : lut_vals(din, m_ff);
    #1 din = nd; rst = nrst;
    sb.push_back('{cfg_en ? 4'b0 : out_vals(din, m_ff), tag});
  endtask

  task automatic set_elem(input int e, input logic [15:0] tt, input logic [3:0] s0,
                          input logic [3:0] s1, input logic [3:0] s2, input logic [3:0] s3,
                          input logic rg);
    m_tt[e] = tt; m_sel[e][0] = s0; m_sel[e][1] = s1; m_sel[e][2] = s2; m_sel[e][3] = s3;
    m_reg[e] = rg;
  endtask

  // R1 image: element e at [33e+32:33e]; [15:0] table, [16+4k+:4] select k, [32] output select
  task automatic load();
    logic [131:0] img;
    @(negedge clk);
    for (int e = 0; e < 4; e++) begin
      img[e*33 +: 16] = m_tt[e];
      for (int k = 0; k < 4; k++) img[e*33 + 16 + 4*k +: 4] = m_sel[e][k];
      img[e*33 + 32] = m_reg[e];
    end
    cfg_en = 1;
    for (int i = 131; i >= 0; i--) begin
      cfg_din = img[i];
      #7 cfg_clk = 1;
      #7 cfg_clk = 0;
      if (i == 60) check(dout, 4'b0, "R8 mid-load");
    end
    cfg_en = 0;
    rst = 1;
    @(posedge clk);
    #1 rst = 0;
    m_ff = 4'b0;
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run incomplete expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 check(dout, 4'b0, "R8 reset state");

    // Config A: AND comb, XOR registered, copy of ff1, self toggle
    set_elem(0, 16'h8000, 4'd0, 4'd1, 4'd2, 4'd3, 1'b0);
    set_elem(1, 16'h6996, 4'd9, 4'd8, 4'd7, 4'd6, 1'b1);
    set_elem(2, 16'hAAAA, 4'd11, 4'd14, 4'd15, 4'd14, 1'b0);
    set_elem(3, 16'h5555, 4'd13, 4'd14, 4'd15, 4'd14, 1'b1);
    load();
    step(10'h00F, 0, "R6 after reset R7");
    step(10'h3C0, 0, "R4 R5 R7");
    for (int n = 0; n < 30; n++) step(10'($urandom), 0, "R1 R3 R4 R5 R7");
    step(10'($urandom), 1, "R6 pre-clear");
    step(10'($urandom), 0, "R6 cleared");
    for (int n = 0; n < 8; n++) step(10'($urandom), 0, "R6 restart R5");

    // Config B: index order, repeated pin, feedback mix
    set_elem(0, 16'h0002, 4'd5, 4'd4, 4'd3, 4'd2, 1'b0);
    set_elem(1, 16'hFFFE, 4'd10, 4'd12, 4'd0, 4'd9, 1'b1);
    set_elem(2, 16'h8000, 4'd9, 4'd9, 4'd9, 4'd9, 1'b0);
    set_elem(3, 16'hCAFE, 4'd3, 4'd6, 4'd11, 4'd10, 1'b0);
    load();
    step(10'b0000100000, 0, "R4 index bit0");
    step(10'b0000110000, 0, "R4 index bit1");
    step(10'b1000000000, 0, "R3 shared pin");
    for (int n = 0; n < 30; n++) step(10'($urandom), 0, "R1 R3 R4 R7");

    // Idle chain clocks with random data must not alter config
    @(negedge clk);
    for (int n = 0; n < 20; n++) begin
      cfg_din = 1'($urandom);
      #3 cfg_clk = 1;
      #3 cfg_clk = 0;
    end
    for (int n = 0; n < 20; n++) step(10'($urandom), 0, "R2 config kept");

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule